// File: doc/BRIEF.md
# Packed Unsigned Saturating SIMD ALU

This execution unit accepts one 32-bit instruction word per cycle, together with the two source operand values. The register file has already read those values. The unit pulls the source and destination register indices and a 3-bit operation code out of the word. It tests the 4-bit condition code against the current N, Z, C and V flags. It then produces a packed unsigned saturating result.

Six operations are available:

- add and subtract on two 16-bit lanes;
- two halfword exchange forms, each pairing one operand's low half with the other operand's high half;
- add and subtract on four 8-bit lanes.

Every lane clamps on its own. A sum that overflows gives all ones in that lane, and a difference that would go negative or reach zero gives zero.

One cycle after a valid input, the unit presents three registered outputs: the result, the destination index and a write-enable. The surrounding pipeline uses them to update the register file. The write-enable is raised only when the condition passes.

Top module: `psimd_sat_alu`

## Requirements
- R1: Field positions in the instruction word: destination index in bits 15:12, first-operand index in bits 19:16, second-operand index in bits 3:0, operation code in bits 7:5, condition in bits 31:28. `src_n_idx` and `src_m_idx` follow the word combinationally. `res_rd` is the destination field of the word accepted on the previous valid cycle.
- R2: Operation code 000 adds the low halves of the two operands and, separately, their high halves, each lane saturating.
- R3: Operation code 001 gives a low half of opn[15:0] minus opm[31:16] and a high half of opn[31:16] plus opm[15:0], each saturating.
- R4: Operation code 010 gives a low half of opn[15:0] plus opm[31:16] and a high half of opn[31:16] minus opm[15:0], each saturating.
- R5: Operation code 011 subtracts each 16-bit lane of opm from the matching lane of opn, each saturating.
- R6: Operation code 100 adds the four bytes lane by lane. Codes 101, 110 and 111 subtract them lane by lane (opn minus opm). Byte i of the result comes from byte i of the operands.
- R7: A saturating add whose true sum does not fit in the lane gives all ones in that lane only (0xFF or 0xFFFF). Otherwise it gives the exact sum.
- R8: A saturating subtract gives zero in a lane whose minuend is less than or equal to its subtrahend. Otherwise it gives the exact difference.
- R9: The `flags` port carries N, Z, C, V in bits 3, 2, 1, 0. The conditions are:
  - 0x0 executes when Z is set and 0x1 when Z is clear.
  - 0x2 executes when C is set and 0x3 when C is clear.
  - 0x4 executes when N is set and 0x5 when N is clear.
  - 0x6 executes when V is set and 0x7 when V is clear.
  - 0x8 executes when C is set and Z is clear; 0x9 when that is false.
  - 0xA executes when N equals V; 0xB when it does not.
  - 0xC executes when Z is clear and N equals V; 0xD when that is false.
  - 0xE always executes and 0xF never executes.

  A failing condition leaves `res_we` low.
- R10: `res_we`, `res_rd` and `res_data` are registered one cycle after `in_valid`. A cycle without `in_valid` gives `res_we` low on the next cycle.
- R11: An active-high synchronous reset drives `res_we` low on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| opn | input | 32 | Value of the first source register |
| opm | input | 32 | Value of the second source register |
| flags | input | 4 | Current N, Z, C, V flags in bits 3..0 |
| src_n_idx | output | 4 | First source register index (combinational) |
| src_m_idx | output | 4 | Second source register index (combinational) |
| res_we | output | 1 | Registered write-enable for the result |
| res_rd | output | 4 | Registered destination register index |
| res_data | output | 32 | Registered packed result |

## Verification
The hardest case to reach from the ports is a single result word in which lanes clamp in different directions at once. For example, one byte saturates high while its neighbour wraps near the carry boundary. In the exchange forms, a low half can clamp to zero while the high half clamps to all ones. The stimulus table sets operand values so that overflowing and non-overflowing lanes sit side by side, including equal-operand subtracts. Condition handling is reached by holding the operation fixed and sweeping the condition code against flag patterns that make each comparison land on both sides.

// File: rtl/psimd_pkg.sv
package psimd_pkg;

    localparam int DATA_W = 32;
    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;
    localparam int N_HALF = DATA_W / HALF_W;
    localparam int N_BYTE = DATA_W / BYTE_W;
    localparam int IDX_W  = 4;

    typedef enum logic [2:0] {
        OP_HADD  = 3'b000,
        OP_HXAS  = 3'b001,
        OP_HXSA  = 3'b010,
        OP_HSUB  = 3'b011,
        OP_BADD  = 3'b100
    } psimd_op_e;

    typedef struct packed {
        logic              we;
        logic [IDX_W-1:0]  rd;
        logic [DATA_W-1:0] data;
    } psimd_res_t;

endpackage

// File: rtl/psimd_sat_lane.sv
module psimd_sat_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    logic [W:0] sum_ext;

    always_comb begin
        sum_ext = {1'b0, a} + {1'b0, b};
        if (sub) begin
            y = (a <= b) ? '0 : (a - b);
        end else begin
            y = sum_ext[W] ? '1 : sum_ext[W-1:0];
        end
    end

    always_comb begin
        if (!sub) begin
            assert_add_never_below_R7: assert (y >= a && y >= b);
        end else begin
            assert_sub_never_above_R8: assert (y <= a);
        end
    end
endmodule

// File: rtl/psimd_cond_eval.sv
module psimd_cond_eval (
    input  logic [3:0] cond,
    input  logic [3:0] flags,
    output logic       pass
);
    logic fn, fz, fc, fv;

    always_comb begin
        {fn, fz, fc, fv} = flags;
        unique case (cond)
            4'h0: pass = fz;
            4'h1: pass = !fz;
            4'h2: pass = fc;
            4'h3: pass = !fc;
            4'h4: pass = fn;
            4'h5: pass = !fn;
            4'h6: pass = fv;
            4'h7: pass = !fv;
            4'h8: pass = fc && !fz;
            4'h9: pass = !(fc && !fz);
            4'hA: pass = (fn == fv);
            4'hB: pass = (fn != fv);
            4'hC: pass = !fz && (fn == fv);
            4'hD: pass = !(!fz && (fn == fv));
            4'hE: pass = 1'b1;
            default: pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/psimd_datapath.sv
module psimd_datapath
    import psimd_pkg::*;
(
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] opn,
    input  logic [DATA_W-1:0] opm,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] half_res;
    logic [DATA_W-1:0] byte_res;
    logic              exch;

    assign exch = (op == OP_HXAS) || (op == OP_HXSA);

    for (genvar i = 0; i < N_HALF; i++) begin : g_half
        logic [HALF_W-1:0] b_sel;
        logic              sub_i;
        always_comb begin
            b_sel = exch ? opm[(N_HALF-1-i)*HALF_W +: HALF_W]
                         : opm[i*HALF_W +: HALF_W];
            sub_i = (op == OP_HSUB)
                 || (op == OP_HXAS && i == 0)
                 || (op == OP_HXSA && i == N_HALF-1);
        end
        psimd_sat_lane #(.W(HALF_W)) lane_i (
            .a   (opn[i*HALF_W +: HALF_W]),
            .b   (b_sel),
            .sub (sub_i),
            .y   (half_res[i*HALF_W +: HALF_W])
        );
    end

    for (genvar j = 0; j < N_BYTE; j++) begin : g_byte
        psimd_sat_lane #(.W(BYTE_W)) lane_j (
            .a   (opn[j*BYTE_W +: BYTE_W]),
            .b   (opm[j*BYTE_W +: BYTE_W]),
            .sub (op != OP_BADD),
            .y   (byte_res[j*BYTE_W +: BYTE_W])
        );
    end

    assign result = op[2] ? byte_res : half_res;
endmodule

// File: rtl/psimd_sat_alu.sv
module psimd_sat_alu
    import psimd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] opn,
    input  logic [DATA_W-1:0] opm,
    input  logic [3:0]        flags,
    output logic [IDX_W-1:0]  src_n_idx,
    output logic [IDX_W-1:0]  src_m_idx,
    output logic              res_we,
    output logic [IDX_W-1:0]  res_rd,
    output logic [DATA_W-1:0] res_data
);
    logic [3:0]        cond_f;
    logic [2:0]        op_f;
    logic [IDX_W-1:0]  rd_f;
    logic              cond_ok;
    logic [DATA_W-1:0] dp_result;
    logic              unused_bits;
    psimd_res_t        out_d, out_q;

    assign cond_f    = instr[31:28];
    assign src_n_idx = instr[19:16];
    assign rd_f      = instr[15:12];
    assign op_f      = instr[7:5];
    assign src_m_idx = instr[3:0];
    assign unused_bits = ^{instr[27:20], instr[11:8], instr[4]};

    psimd_cond_eval cond_i (
        .cond  (cond_f),
        .flags (flags),
        .pass  (cond_ok)
    );

    psimd_datapath dp_i (
        .op     (op_f),
        .opn    (opn),
        .opm    (opm),
        .result (dp_result)
    );

    always_comb begin
        out_d    = out_q;
        out_d.we = in_valid && cond_ok;
        if (in_valid) begin
            out_d.rd   = rd_f;
            out_d.data = dp_result;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign res_we   = out_q.we;
    assign res_rd   = out_q.rd;
    assign res_data = out_q.data;

    assert_idle_no_write_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_we);
    assert_dest_field_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_rd == $past(instr[15:12]));
    assert_always_cond_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[31:28] == 4'hE) |=> res_we);
    assert_never_cond_R9: assert property (@(posedge clk) disable iff (rst)
        (instr[31:28] == 4'hF) |=> !res_we);
    assert_reset_clears_R11: assert property (@(posedge clk)
        rst |=> !res_we);
endmodule

// File: tb/psimd_sat_alu_tb.sv
`timescale 1ns/1ps
module psimd_sat_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] instr, opn, opm;
    logic [3:0]  flags;
    logic [3:0]  src_n_idx, src_m_idx, res_rd;
    logic        res_we;
    logic [31:0] res_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    psimd_sat_alu dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .opn(opn), .opm(opm), .flags(flags),
        .src_n_idx(src_n_idx), .src_m_idx(src_m_idx),
        .res_we(res_we), .res_rd(res_rd), .res_data(res_data)
    );

    typedef struct packed {
        bit [23:0] tag;
        bit [2:0]  op;
        bit [31:0] rn;
        bit [31:0] rm;
        bit [31:0] exp;
    } vec_t;

    localparam vec_t VECS [0:12] = '{
        '{"R2", 3'd0, 32'h0001_FFF0, 32'h0002_0010, 32'h0003_FFFF},
        '{"R2", 3'd0, 32'h1234_0100, 32'h0001_0200, 32'h1235_0300},
        '{"R3", 3'd1, 32'h8000_0005, 32'h0003_FFFF, 32'hFFFF_0002},
        '{"R3", 3'd1, 32'h0010_0002, 32'h0005_0020, 32'h0030_0000},
        '{"R4", 3'd2, 32'h0100_0010, 32'h0020_0050, 32'h00B0_0030},
        '{"R4", 3'd2, 32'h0004_FFFE, 32'h0003_0004, 32'h0000_FFFF},
        '{"R5", 3'd3, 32'h5000_0003, 32'h1000_0007, 32'h4000_0000},
        '{"R8", 3'd3, 32'hABCD_1234, 32'hABCD_0234, 32'h0000_1000},
        '{"R7", 3'd4, 32'h80FF_0110, 32'h8001_FF20, 32'hFFFF_FF30},
        '{"R6", 3'd4, 32'h0102_0304, 32'h1020_3040, 32'h1122_3344},
        '{"R8", 3'd5, 32'h1020_3040, 32'h0140_3050, 32'h0F00_0000},
        '{"R6", 3'd6, 32'hFF00_8001, 32'h0101_7F00, 32'hFE00_0101},
        '{"R6", 3'd7, 32'hFFFF_FFFF, 32'h0102_0304, 32'hFEFD_FCFB}
    };

    function automatic logic [31:0] mk(input logic [3:0] c, input logic [2:0] op,
                                       input logic [3:0] rn, input logic [3:0] rd,
                                       input logic [3:0] rm);
        return {c, 8'h66, rn, rd, 4'hF, op, 1'b1, rm};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at negedge, one posedge, sample at the following negedge.
    task automatic issue(input logic [31:0] w, input logic [31:0] a,
                         input logic [31:0] b, input logic [3:0] f);
        @(negedge clk);
        instr = w; opn = a; opm = b; flags = f; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic cond_case(input string tag, input logic [3:0] c,
                             input logic [3:0] f, input logic exp_we);
        issue(mk(c, 3'd0, 4'd1, 4'd2, 4'd3), 32'h1, 32'h1, f);
        chk(tag, {31'd0, res_we}, {31'd0, exp_we});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; instr = '0; opn = '0; opm = '0; flags = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 reset", {31'd0, res_we}, 32'd0);
        rst = 1'b0;

        // Table walk: always-execute condition, varying destinations.
        for (int i = 0; i <= 12; i++) begin
            issue(mk(4'hE, VECS[i].op, 4'(i), 4'(15 - i), 4'(i + 1)),
                  VECS[i].rn, VECS[i].rm, 4'h0);
            chk($sformatf("%s vec%0d", VECS[i].tag, i), res_data, VECS[i].exp);
            chk($sformatf("R1 rd vec%0d", i), {28'd0, res_rd}, 32'(15 - i));
            chk($sformatf("R9 we vec%0d", i), {31'd0, res_we}, 32'd1);
        end

        // R1: source indices combinational
        @(negedge clk);
        instr = mk(4'hE, 3'd0, 4'hA, 4'h5, 4'h3);
        #1;
        chk("R1 src_n", {28'd0, src_n_idx}, 32'hA);
        chk("R1 src_m", {28'd0, src_m_idx}, 32'h3);

        // R10: idle cycle yields no write
        @(negedge clk);
        chk("R10 idle", {31'd0, res_we}, 32'd0);

        // R9: condition sweep (flags = N Z C V)
        cond_case("R9 EQ taken",   4'h0, 4'b0100, 1'b1);
        cond_case("R9 EQ skip",    4'h0, 4'b0000, 1'b0);
        cond_case("R9 NE taken",   4'h1, 4'b0000, 1'b1);
        cond_case("R9 CC skip",    4'h3, 4'b0010, 1'b0);
        cond_case("R9 MI taken",   4'h4, 4'b1000, 1'b1);
        cond_case("R9 VC skip",    4'h7, 4'b0001, 1'b0);
        cond_case("R9 HI taken",   4'h8, 4'b0010, 1'b1);
        cond_case("R9 HI skip",    4'h8, 4'b0110, 1'b0);
        cond_case("R9 LS taken",   4'h9, 4'b0110, 1'b1);
        cond_case("R9 GE taken",   4'hA, 4'b1001, 1'b1);
        cond_case("R9 LT taken",   4'hB, 4'b1000, 1'b1);
        cond_case("R9 GT skip",    4'hC, 4'b0100, 1'b0);
        cond_case("R9 GT taken",   4'hC, 4'b0000, 1'b1);
        cond_case("R9 LE taken",   4'hD, 4'b0001, 1'b1);
        cond_case("R9 NV skip",    4'hF, 4'b0000, 1'b0);
        cond_case("R9 AL taken",   4'hE, 4'b1111, 1'b1);

        // R10: valid dropped after issue gives we low next cycle
        @(negedge clk);
        chk("R10 drop", {31'd0, res_we}, 32'd0);

        // R11: reset asserted with a valid input suppresses the write
        @(negedge clk);
        instr = mk(4'hE, 3'd0, 4'd1, 4'd2, 4'd3); in_valid = 1'b1; rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R11 reset over valid", {31'd0, res_we}, 32'd0);
        rst = 1'b0; in_valid = 1'b0;

        // R7/R8: all-lane extremes
        issue(mk(4'hE, 3'd0, 4'd1, 4'd2, 4'd3), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'h0);
        chk("R7 full halves", res_data, 32'hFFFF_FFFF);
        issue(mk(4'hE, 3'd3, 4'd1, 4'd2, 4'd3), 32'h0000_0000, 32'h0001_0001, 4'h0);
        chk("R8 zero halves", res_data, 32'h0000_0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule